// File: doc/BRIEF.md
# Timestamp-Validated Shared Data Buffer

This block is a per-processor buffer of global data words. Coherence between processors relies on when each entry was loaded, not on bus snooping. Every entry holds its data, a valid bit, a modified bit and the value of a shared time base from the moment the entry was last filled or written. The time base is supplied from outside the block and is common to all processors, so timestamps from different processors can be compared.

Critical sections are bounded by semaphore events. A close event carries the opening time held in the semaphore. From then on, any entry stamped before that time misses on its next access and is re-read from memory. Entries stamped later keep hitting. An open event stamps the current time for the semaphore to keep, and writes back every entry modified inside the section, one word at a time, through the memory port. Writes made outside a critical section go straight through to memory. Semaphore state, blocking and thread queues sit outside this block.

Top module: `shared_stamp_buffer`

## Requirements
- R1: After reset, reqReady is 1 and memReq, rspValid and openDone are 0, and every entry is invalid, so the first read of any address misses.
- R2: A read whose entry is valid and not stale returns the stored word with rspValid one cycle after acceptance, and makes no memory request.
- R3: A read that misses raises memReq with memWrite 0 at that address. memReq and memAddr stay stable until memAck. The response with memRdata follows one cycle after memAck, and the entry is filled and stamped with timeNow.
- R4: A write accepted between a close and the next open updates the entry, marks it modified, stamps it with timeNow and is acknowledged one cycle later with no memory traffic; a following read of that address hits with the new word.
- R5: A write accepted outside a critical section updates the entry and issues one memory write (memWrite 1) of the same word. rspValid follows one cycle after memAck.
- R6: A close captures semCloseTime as the stale bound. Afterwards a read of an entry whose stamp minus the bound is negative as a TW-bit two's-complement value misses and refetches; an entry stamped at or after the bound hits.
- R7: An open presents the timeNow value of its acceptance cycle on semStampOut from the next cycle, ends the critical section, and writes each modified entry back to memory as one memory write per entry; openDone pulses for one cycle when the sequence ends.
- R8: An open with no modified entry produces no memory request and still pulses openDone within DEPTH+2 cycles.
- R9: reqReady is 0 while a miss, a write-through or an open sequence is in progress, and in any cycle where semCloseReq or semOpenReq is high; a request offered together with a semaphore event is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timeNow | input | TW | Shared system time base |
| reqValid | input | 1 | Access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | AW | Word address |
| reqWdata | input | DW | Write word |
| reqReady | output | 1 | Request accepted this cycle when high with reqValid |
| rspValid | output | 1 | Response pulse |
| rspData | output | DW | Read word or echoed write word |
| semCloseReq | input | 1 | Semaphore close event (critical section begins) |
| semCloseTime | input | TW | Opening time stored in the semaphore |
| semOpenReq | input | 1 | Semaphore open event (critical section ends) |
| semStampOut | output | TW | Time captured at the last open, for the semaphore |
| openDone | output | 1 | Write-back sequence finished |
| memReq | output | 1 | Memory request, held until memAck |
| memWrite | output | 1 | Memory request is a write |
| memAddr | output | AW | Memory word address |
| memWdata | output | DW | Memory write word |
| memAck | input | 1 | One-cycle memory completion |
| memRdata | input | DW | Memory read word, valid with memAck |

## Verification
The assertions take four things for granted about the inputs. memAck is a single-cycle pulse that only answers a pending memReq. The time base only moves forward. Fewer than 2^(TW-1) cycles pass between a stamp and the close it is compared with. Semaphore events arrive only while the block is idle. The bench meets this with a memory responder that acknowledges one cycle after each request and a 32-bit counter as the time base. Its semaphore model issues close and open events only between finished accesses, and offers a request at the same time as a close only once, to probe the priority rule. Two instances share one memory image and one semaphore model, which replay a shared counter being incremented under the lock so that stale and fresh copies can both be observed.

// File: rtl/ssb_pkg.sv
package ssb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MISS,
    ST_WTHRU,
    ST_SCAN,
    ST_WB
  } ssbState_e;

  typedef struct packed {
    logic latchReq;
    logic wrCommon;
    logic wrPlain;
    logic rspHit;
    logic fill;
    logic captureClose;
    logic captureOpen;
    logic scanClr;
    logic scanInc;
    logic clearDirty;
    logic selScan;
  } ssbStrobe_t;

endpackage

// File: rtl/ssb_data.sv
module ssb_data
  import ssb_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 64,
  parameter int TW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  ssbStrobe_t    strb,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  input  logic [TW-1:0] timeNow,
  input  logic [TW-1:0] semCloseTime,
  input  logic [DW-1:0] memRdata,
  output logic          hit,
  output logic          inSection,
  output logic          dirtyAtScan,
  output logic          scanLast,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [DW-1:0] rspData,
  output logic [TW-1:0] semStampOut
);

  logic [DW-1:0]    dataMem  [DEPTH];
  logic [TW-1:0]    stampMem [DEPTH];
  logic [DEPTH-1:0] validV;
  logic [DEPTH-1:0] dirtyV;
  logic [AW-1:0]    addrQ;
  logic [DW-1:0]    wdataQ;
  logic [AW-1:0]    scanIdx;
  logic [TW-1:0]    staleBound;
  logic [TW-1:0]    ageDiff;

  // modular age against the bound: negative means loaded before the open
  assign ageDiff     = stampMem[reqAddr] - staleBound;
  assign hit         = validV[reqAddr] && !ageDiff[TW-1];
  assign dirtyAtScan = dirtyV[scanIdx];
  assign scanLast    = (scanIdx == AW'(DEPTH - 1));
  assign memAddr     = strb.selScan ? scanIdx : addrQ;
  assign memWdata    = strb.selScan ? dataMem[scanIdx] : wdataQ;

  always_ff @(posedge clk) begin
    if (strb.wrCommon || strb.wrPlain) begin
      dataMem[reqAddr]  <= reqWdata;
      stampMem[reqAddr] <= timeNow;
    end else if (strb.fill) begin
      dataMem[addrQ]  <= memRdata;
      stampMem[addrQ] <= timeNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validV      <= '0;
      dirtyV      <= '0;
      addrQ       <= '0;
      wdataQ      <= '0;
      scanIdx     <= '0;
      staleBound  <= '0;
      inSection   <= 1'b0;
      semStampOut <= '0;
      rspData     <= '0;
    end else begin
      if (strb.latchReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.wrCommon) begin
        validV[reqAddr] <= 1'b1;
        dirtyV[reqAddr] <= 1'b1;
      end
      if (strb.wrPlain) begin
        validV[reqAddr] <= 1'b1;
        dirtyV[reqAddr] <= 1'b0;
      end
      if (strb.fill) begin
        validV[addrQ] <= 1'b1;
        rspData       <= memRdata;
      end
      if (strb.rspHit) rspData <= dataMem[reqAddr];
      if (strb.wrCommon || strb.wrPlain) rspData <= reqWdata;
      if (strb.clearDirty) dirtyV[scanIdx] <= 1'b0;
      if (strb.scanClr) scanIdx <= '0;
      else if (strb.scanInc) scanIdx <= scanIdx + 1'b1;
      if (strb.captureClose) begin
        staleBound <= semCloseTime;
        inSection  <= 1'b1;
      end
      if (strb.captureOpen) begin
        semStampOut <= timeNow;
        inSection   <= 1'b0;
      end
    end
  end

  a_r3_fill_stamp: assert property (@(posedge clk) disable iff (!rstN)
    strb.fill |=> (stampMem[$past(addrQ)] == $past(timeNow)) && validV[$past(addrQ)]);

  a_r4_mark_dirty: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCommon |=> dirtyV[$past(reqAddr)] && (dataMem[$past(reqAddr)] == $past(reqWdata)));

  a_r6_bound_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureClose |=> (staleBound == $past(semCloseTime)) && inSection);

  a_r7_open_stamp: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureOpen |=> (semStampOut == $past(timeNow)) && !inSection);

endmodule

// File: rtl/ssb_ctrl.sv
module ssb_ctrl
  import ssb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       semCloseReq,
  input  logic       semOpenReq,
  input  logic       memAck,
  input  logic       hit,
  input  logic       inSection,
  input  logic       dirtyAtScan,
  input  logic       scanLast,
  output ssbStrobe_t strb,
  output logic       reqReady,
  output logic       rspValid,
  output logic       memReq,
  output logic       memWrite,
  output logic       openDone
);

  ssbState_e state, nextState;
  logic      rspNext;
  logic      doneNext;

  always_comb begin
    strb      = '0;
    nextState = state;
    reqReady  = 1'b0;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    rspNext   = 1'b0;
    doneNext  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = !semCloseReq && !semOpenReq;
        if (semCloseReq) begin
          strb.captureClose = 1'b1;
        end else if (semOpenReq) begin
          strb.captureOpen = 1'b1;
          strb.scanClr     = 1'b1;
          nextState        = ST_SCAN;
        end else if (reqValid) begin
          strb.latchReq = 1'b1;
          if (reqWrite) begin
            if (inSection) begin
              strb.wrCommon = 1'b1;
              rspNext       = 1'b1;
            end else begin
              strb.wrPlain = 1'b1;
              nextState    = ST_WTHRU;
            end
          end else if (hit) begin
            strb.rspHit = 1'b1;
            rspNext     = 1'b1;
          end else begin
            nextState = ST_MISS;
          end
        end
      end
      ST_MISS: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.fill = 1'b1;
          rspNext   = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_WTHRU: begin
        memReq   = 1'b1;
        memWrite = 1'b1;
        if (memAck) begin
          rspNext   = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_SCAN: begin
        if (dirtyAtScan) begin
          nextState = ST_WB;
        end else if (scanLast) begin
          doneNext  = 1'b1;
          nextState = ST_IDLE;
        end else begin
          strb.scanInc = 1'b1;
        end
      end
      ST_WB: begin
        memReq       = 1'b1;
        memWrite     = 1'b1;
        strb.selScan = 1'b1;
        if (memAck) begin
          strb.clearDirty = 1'b1;
          if (scanLast) begin
            doneNext  = 1'b1;
            nextState = ST_IDLE;
          end else begin
            strb.scanInc = 1'b1;
            nextState    = ST_SCAN;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rspValid <= 1'b0;
      openDone <= 1'b0;
    end else begin
      state    <= nextState;
      rspValid <= rspNext;
      openDone <= doneNext;
    end
  end

  a_r9_rsp_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !memReq);

  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    openDone |-> !memReq && !rspValid);

  a_r9_sem_priority: assert property (@(posedge clk) disable iff (!rstN)
    (semCloseReq || semOpenReq) |-> !reqReady);

endmodule

// File: rtl/shared_stamp_buffer.sv
module shared_stamp_buffer
  import ssb_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 64,
  parameter int TW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [TW-1:0] timeNow,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  output logic          reqReady,
  output logic          rspValid,
  output logic [DW-1:0] rspData,
  input  logic          semCloseReq,
  input  logic [TW-1:0] semCloseTime,
  input  logic          semOpenReq,
  output logic [TW-1:0] semStampOut,
  output logic          openDone,
  output logic          memReq,
  output logic          memWrite,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic          memAck,
  input  logic [DW-1:0] memRdata
);

  ssbStrobe_t strb;
  logic       hit;
  logic       inSection;
  logic       dirtyAtScan;
  logic       scanLast;

  ssb_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .semCloseReq(semCloseReq),
    .semOpenReq (semOpenReq),
    .memAck     (memAck),
    .hit        (hit),
    .inSection  (inSection),
    .dirtyAtScan(dirtyAtScan),
    .scanLast   (scanLast),
    .strb       (strb),
    .reqReady   (reqReady),
    .rspValid   (rspValid),
    .memReq     (memReq),
    .memWrite   (memWrite),
    .openDone   (openDone)
  );

  ssb_data #(
    .DEPTH(DEPTH),
    .DW   (DW),
    .TW   (TW)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .timeNow     (timeNow),
    .semCloseTime(semCloseTime),
    .memRdata    (memRdata),
    .hit         (hit),
    .inSection   (inSection),
    .dirtyAtScan (dirtyAtScan),
    .scanLast    (scanLast),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .rspData     (rspData),
    .semStampOut (semStampOut)
  );

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq && $stable(memAddr) && $stable(memWrite));

endmodule

// File: tb/shared_stamp_buffer_test.sv
module shared_stamp_buffer_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int DW = 32;
  localparam int TW = 32;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [TW-1:0] timeNow;

  logic          reqValid [2];
  logic          reqWrite [2];
  logic [AW-1:0] reqAddr [2];
  logic [DW-1:0] reqWdata [2];
  logic          reqReady [2];
  logic          rspValid [2];
  logic [DW-1:0] rspData [2];
  logic          semCloseReq [2];
  logic [TW-1:0] semCloseTime [2];
  logic          semOpenReq [2];
  logic [TW-1:0] semStampOut [2];
  logic          openDone [2];
  logic          memReq [2];
  logic          memWrite [2];
  logic [AW-1:0] memAddr [2];
  logic [DW-1:0] memWdata [2];
  logic          memAck [2];
  logic [DW-1:0] memRdata [2];

  logic [DW-1:0] mem [DEPTH];
  int memCnt [2];

  int nChecks = 0;
  int nFail = 0;
  int semTime = 0;
  bit semShut = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rstN) timeNow <= '0;
    else timeNow <= timeNow + 1'b1;
  end

  // shared memory image with a one-cycle acknowledging responder per port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(100 + 3 * i);
      for (int p = 0; p < 2; p++) begin
        memAck[p]   <= 1'b0;
        memRdata[p] <= '0;
        memCnt[p]   <= 0;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        memAck[p] <= memReq[p] && !memAck[p];
        if (memReq[p] && !memAck[p]) begin
          memRdata[p] <= mem[memAddr[p]];
          if (memWrite[p]) mem[memAddr[p]] <= memWdata[p];
        end
        if (memReq[p] && memAck[p]) memCnt[p] <= memCnt[p] + 1;
      end
    end
  end

  shared_stamp_buffer #(.DEPTH(DEPTH), .DW(DW), .TW(TW)) uut (
    .clk(clk), .rstN(rstN), .timeNow(timeNow),
    .reqValid(reqValid[0]), .reqWrite(reqWrite[0]), .reqAddr(reqAddr[0]),
    .reqWdata(reqWdata[0]), .reqReady(reqReady[0]), .rspValid(rspValid[0]),
    .rspData(rspData[0]), .semCloseReq(semCloseReq[0]),
    .semCloseTime(semCloseTime[0]), .semOpenReq(semOpenReq[0]),
    .semStampOut(semStampOut[0]), .openDone(openDone[0]),
    .memReq(memReq[0]), .memWrite(memWrite[0]), .memAddr(memAddr[0]),
    .memWdata(memWdata[0]), .memAck(memAck[0]), .memRdata(memRdata[0])
  );

  shared_stamp_buffer #(.DEPTH(DEPTH), .DW(DW), .TW(TW)) uutPeer (
    .clk(clk), .rstN(rstN), .timeNow(timeNow),
    .reqValid(reqValid[1]), .reqWrite(reqWrite[1]), .reqAddr(reqAddr[1]),
    .reqWdata(reqWdata[1]), .reqReady(reqReady[1]), .rspValid(rspValid[1]),
    .rspData(rspData[1]), .semCloseReq(semCloseReq[1]),
    .semCloseTime(semCloseTime[1]), .semOpenReq(semOpenReq[1]),
    .semStampOut(semStampOut[1]), .openDone(openDone[1]),
    .memReq(memReq[1]), .memWrite(memWrite[1]), .memAddr(memAddr[1]),
    .memWdata(memWdata[1]), .memAck(memAck[1]), .memRdata(memRdata[1])
  );

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReq(int p, bit wr, int addr, logic [DW-1:0] wdata,
                       logic [DW-1:0] expData, int expDelta, bit expWait, string req);
    int base;
    int n;
    @(negedge clk);
    while (!reqReady[p]) @(negedge clk);
    base = memCnt[p];
    reqValid[p] = 1'b1;
    reqWrite[p] = wr;
    reqAddr[p]  = AW'(addr);
    reqWdata[p] = wdata;
    @(negedge clk);
    reqValid[p] = 1'b0;
    if (expWait) check(reqReady[p] == 1'b0, "R9", "ready while busy", 64'(reqReady[p]), 0);
    n = 0;
    while (!rspValid[p] && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(rspValid[p] == 1'b1, req, "response seen", 64'(rspValid[p]), 1);
    check(rspData[p] == expData, req, "response word", 64'(rspData[p]), 64'(expData));
    check(memCnt[p] - base == expDelta, req, "memory accesses", 64'(memCnt[p] - base), 64'(expDelta));
    if (!expWait) check(n == 0, req, "hit latency", 64'(n), 0);
  endtask

  task automatic doClose(int p);
    check(semShut == 1'b0, "R6", "semaphore model free", 64'(semShut), 0);
    @(negedge clk);
    semCloseReq[p]  = 1'b1;
    semCloseTime[p] = TW'(semTime);
    @(negedge clk);
    semCloseReq[p] = 1'b0;
    semShut = 1'b1;
  endtask

  task automatic doOpen(int p, int expWrites, string req);
    int base;
    int n;
    logic [TW-1:0] t;
    @(negedge clk);
    t = timeNow;
    base = memCnt[p];
    semOpenReq[p] = 1'b1;
    @(negedge clk);
    semOpenReq[p] = 1'b0;
    check(semStampOut[p] == t, "R7", "open stamp", 64'(semStampOut[p]), 64'(t));
    semTime = int'(t);
    semShut = 1'b0;
    n = 0;
    while (!openDone[p] && n < DEPTH + 4 + 4 * expWrites) begin
      @(negedge clk);
      n++;
    end
    check(openDone[p] == 1'b1, req, "open done", 64'(openDone[p]), 1);
    check(memCnt[p] - base == expWrites, req, "write-backs", 64'(memCnt[p] - base), 64'(expWrites));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      reqValid[p] = 1'b0; reqWrite[p] = 1'b0; reqAddr[p] = '0; reqWdata[p] = '0;
      semCloseReq[p] = 1'b0; semCloseTime[p] = '0; semOpenReq[p] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      check(reqReady[p] == 1'b1, "R1", "ready after reset", 64'(reqReady[p]), 1);
      check(memReq[p] == 1'b0 && rspValid[p] == 1'b0 && openDone[p] == 1'b0,
            "R1", "quiet after reset", 64'({memReq[p], rspValid[p], openDone[p]}), 0);
    end
    @(negedge clk);
    mem[5] = 10;  // shared counter

    // peer caches the counter before anyone locks it
    doReq(1, 0, 5, 0, 10, 1, 1, "R1");
    doReq(1, 0, 5, 0, 10, 0, 0, "R2");

    // processor 0 increments under the lock
    doClose(0);
    doReq(0, 0, 5, 0, 10, 1, 1, "R3");
    doReq(0, 1, 5, 11, 11, 0, 0, "R4");
    doReq(0, 0, 5, 0, 11, 0, 0, "R4");
    doReq(0, 1, 9, 77, 77, 0, 0, "R4");
    check(mem[5] == 10, "R4", "memory untouched in section", 64'(mem[5]), 10);
    doOpen(0, 2, "R7");
    check(mem[5] == 11 && mem[9] == 77, "R7", "written back", 64'({mem[5], mem[9]}), 64'({32'd11, 32'd77}));

    // peer loads an entry after that open, then locks and increments
    doReq(1, 0, 7, 0, DW'(121), 1, 1, "R3");
    doClose(1);
    doReq(1, 0, 5, 0, 11, 1, 1, "R6");
    doReq(1, 0, 7, 0, DW'(121), 0, 0, "R6");
    doReq(1, 1, 5, 12, 12, 0, 0, "R4");
    doOpen(1, 1, "R7");
    check(mem[5] == 12, "R7", "peer write-back", 64'(mem[5]), 12);

    // lock and release with nothing modified
    doClose(1);
    doOpen(1, 0, "R8");

    // processor 0 sees the peer's increment
    doClose(0);
    doReq(0, 0, 5, 0, 12, 1, 1, "R6");
    doOpen(0, 0, "R8");

    // write outside any critical section goes through
    doReq(0, 1, 20, 55, 55, 1, 1, "R5");
    check(mem[20] == 55, "R5", "write-through", 64'(mem[20]), 55);
    doReq(0, 0, 20, 0, 55, 0, 0, "R5");

    // a request offered with a close is not taken
    @(negedge clk);
    semCloseReq[0] = 1'b1;
    semCloseTime[0] = TW'(semTime);
    reqValid[0] = 1'b1;
    reqWrite[0] = 1'b0;
    reqAddr[0] = AW'(20);
    #1;
    check(reqReady[0] == 1'b0, "R9", "ready with close", 64'(reqReady[0]), 0);
    @(negedge clk);
    semCloseReq[0] = 1'b0;
    reqValid[0] = 1'b0;
    semShut = 1'b1;
    @(negedge clk);
    check(rspValid[0] == 1'b0, "R9", "no response to blocked request", 64'(rspValid[0]), 0);
    doOpen(0, 0, "R8");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule